// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the eight status bits of a small 8-bit processor core. Five of them are arithmetic flags (carry, zero, negative, two's-complement overflow and half carry), along with a sign bit, a bit-copy storage bit (T) and the global interrupt enable (I). The ALU sends each flag result with its own update enable. A bit-store port copies one chosen bit of a register value into T. A combinational bit-load helper returns a supplied byte with one chosen bit replaced by T.

The interrupt enable is changed in four ways. Dedicated set and clear strobes change it. Accepting an interrupt clears it. The return-from-interrupt strobe sets it again. The block also gates the core's interrupt request, so no source gets through while I is low. Software can read and write the whole register through the I/O port at I/O address 0x3F, which is data-space address 0x5F. Interrupt entry and return do not save or restore the register: they change only I. The sign bit is never stored on its own. It always follows N xor V.

Top module: `cpu_status_reg`

## Requirements
- R1: After reset every bit of `sreg` is 0, and `irq_req` is 0 even when all sources are pending and individually enabled.
- R2: The bit layout from bit 7 down to bit 0 is I, T, H, S, V, N, Z, C. Each ALU flag (C, Z, N, V, H) loads its value only in a cycle where its own enable is high. Flags whose enable is low keep their value.
- R3: The S bit (bit 4) equals N xor V of the stored flags at all times. This includes after an I/O write, where the written bit 4 is ignored.
- R4: With `io_addr` = 0x3F, `io_rdata` returns `sreg`, and at any other address it returns 0. A write with `io_we` at 0x3F loads I, T, H, V, N, Z and C from `io_wdata`. A write at any other address changes nothing.
- R5: `sei_stb` sets I and `cli_stb` clears it. When both arrive in the same cycle, I is cleared.
- R6: `irq_ack` clears I in the next cycle. It overrides every other source of I in that cycle, including an I/O write, `sei_stb` and `reti_stb`.
- R7: `reti_stb` sets I unless `irq_ack` is high in the same cycle. Neither `reti_stb` nor `irq_ack` changes any bit other than I.
- R8: `irq_req` is high exactly when I is 1 and at least one bit of `irq_src & irq_en` is 1.
- R9: When `bst_en` is high, T loads bit `bit_sel` of `bst_src`, with bit 0 being the LSB.
- R10: `bld_out` equals `bld_in` with bit `bit_sel` replaced by the current T. All other bits pass through unchanged.
- R11: An I/O write at 0x3F overrides ALU flag updates, the bit store, `sei_stb`, `cli_stb` and `reti_stb` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alu_c | input | 1 | ALU carry result |
| alu_c_we | input | 1 | Update enable for carry |
| alu_z | input | 1 | ALU zero result |
| alu_z_we | input | 1 | Update enable for zero |
| alu_n | input | 1 | ALU negative result |
| alu_n_we | input | 1 | Update enable for negative |
| alu_v | input | 1 | ALU overflow result |
| alu_v_we | input | 1 | Update enable for overflow |
| alu_h | input | 1 | ALU half-carry result |
| alu_h_we | input | 1 | Update enable for half carry |
| sei_stb | input | 1 | Set the interrupt enable |
| cli_stb | input | 1 | Clear the interrupt enable |
| reti_stb | input | 1 | Return from interrupt: set I |
| irq_ack | input | 1 | Interrupt accepted: clear I |
| bst_en | input | 1 | Bit store into T |
| bst_src | input | 8 | Register value for the bit store |
| bit_sel | input | 3 | Bit select for bit store and bit load |
| bld_in | input | 8 | Byte for the bit-load helper |
| bld_out | output | 8 | `bld_in` with the selected bit set to T |
| io_addr | input | 6 | I/O address |
| io_we | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data |
| irq_src | input | NUM_IRQ | Pending interrupt sources |
| irq_en | input | NUM_IRQ | Individual interrupt enables |
| irq_req | output | 1 | Gated interrupt request |
| sreg | output | 8 | Register value |

## Verification
The timing assertions assume the core is well behaved. Strobes are sampled as single-cycle pulses, and `bit_sel` is stable while `bst_en` is high. The I-related properties also assume no competing writer is active except the ones each property excludes. The directed tasks drive every input right after a rising edge and drop each strobe one cycle later. They also stack conflicting strobes only in the cycles that test priority, so every collision is intended and its winner is known in advance.

// File: rtl/stat_pkg.sv
package stat_pkg;
    localparam int SREG_W = 8;
    localparam int SEL_W  = $clog2(SREG_W);
    localparam int IO_AW  = 6;
    localparam logic [IO_AW-1:0] SREG_IO_ADDR = 6'h3F;

    localparam int BIT_C = 0;
    localparam int BIT_Z = 1;
    localparam int BIT_N = 2;
    localparam int BIT_V = 3;
    localparam int BIT_S = 4;
    localparam int BIT_H = 5;
    localparam int BIT_T = 6;
    localparam int BIT_I = 7;

    typedef struct packed {
        logic i;
        logic t;
        logic h;
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } sreg_t;
endpackage

// File: rtl/stat_bitops.sv
module stat_bitops
    import stat_pkg::*;
#(
    parameter int W = SREG_W,
    localparam int SW = $clog2(W)
) (
    input  logic          t_bit,
    input  logic [W-1:0]  bst_src,
    input  logic [SW-1:0] bit_sel,
    input  logic [W-1:0]  bld_in,
    output logic          bst_bit,
    output logic [W-1:0]  bld_out
);
    assign bst_bit = bst_src[bit_sel];

    for (genvar g = 0; g < W; g++) begin : g_ins
        assign bld_out[g] = (bit_sel == SW'(g)) ? t_bit : bld_in[g];
    end
endmodule

// File: rtl/stat_ie_next.sv
module stat_ie_next (
    input  logic cur_i,
    input  logic ack,
    input  logic io_wr,
    input  logic io_val,
    input  logic sei,
    input  logic cli,
    input  logic reti,
    output logic nxt_i
);
    // lowest priority first; later assignments win
    always_comb begin
        nxt_i = cur_i;
        if (sei || reti) nxt_i = 1'b1;
        if (cli)         nxt_i = 1'b0;
        if (io_wr)       nxt_i = io_val;
        if (ack)         nxt_i = 1'b0;
    end
endmodule

// File: rtl/stat_irq_gate.sv
module stat_irq_gate #(
    parameter int NUM_IRQ = 4
) (
    input  logic               global_en,
    input  logic [NUM_IRQ-1:0] src,
    input  logic [NUM_IRQ-1:0] en,
    output logic               req
);
    logic [NUM_IRQ-1:0] live;
    assign live = src & en;
    assign req  = global_en & (|live);
endmodule

// File: rtl/cpu_status_reg.sv
module cpu_status_reg
    import stat_pkg::*;
#(
    parameter int NUM_IRQ = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alu_c,
    input  logic               alu_c_we,
    input  logic               alu_z,
    input  logic               alu_z_we,
    input  logic               alu_n,
    input  logic               alu_n_we,
    input  logic               alu_v,
    input  logic               alu_v_we,
    input  logic               alu_h,
    input  logic               alu_h_we,
    input  logic               sei_stb,
    input  logic               cli_stb,
    input  logic               reti_stb,
    input  logic               irq_ack,
    input  logic               bst_en,
    input  logic [SREG_W-1:0]  bst_src,
    input  logic [SEL_W-1:0]   bit_sel,
    input  logic [SREG_W-1:0]  bld_in,
    output logic [SREG_W-1:0]  bld_out,
    input  logic [IO_AW-1:0]   io_addr,
    input  logic               io_we,
    input  logic [SREG_W-1:0]  io_wdata,
    output logic [SREG_W-1:0]  io_rdata,
    input  logic [NUM_IRQ-1:0] irq_src,
    input  logic [NUM_IRQ-1:0] irq_en,
    output logic               irq_req,
    output logic [SREG_W-1:0]  sreg
);
    sreg_t state_d, state_q;
    logic  io_sel, io_wr_hit, bst_bit, i_d;
    sreg_t io_word;

    assign io_sel    = (io_addr == SREG_IO_ADDR);
    assign io_wr_hit = io_sel && io_we;
    assign io_word   = sreg_t'(io_wdata);

    stat_bitops #(.W(SREG_W)) u_bitops (
        .t_bit   (state_q.t),
        .bst_src (bst_src),
        .bit_sel (bit_sel),
        .bld_in  (bld_in),
        .bst_bit (bst_bit),
        .bld_out (bld_out)
    );

    stat_ie_next u_ie (
        .cur_i  (state_q.i),
        .ack    (irq_ack),
        .io_wr  (io_wr_hit),
        .io_val (io_word.i),
        .sei    (sei_stb),
        .cli    (cli_stb),
        .reti   (reti_stb),
        .nxt_i  (i_d)
    );

    stat_irq_gate #(.NUM_IRQ(NUM_IRQ)) u_gate (
        .global_en (state_q.i),
        .src       (irq_src),
        .en        (irq_en),
        .req       (irq_req)
    );

    always_comb begin
        state_d = state_q;
        if (alu_c_we) state_d.c = alu_c;
        if (alu_z_we) state_d.z = alu_z;
        if (alu_n_we) state_d.n = alu_n;
        if (alu_v_we) state_d.v = alu_v;
        if (alu_h_we) state_d.h = alu_h;
        if (bst_en)   state_d.t = bst_bit;
        if (io_wr_hit) state_d = io_word;
        state_d.i = i_d;
        state_d.s = state_d.n ^ state_d.v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign sreg     = state_q;
    assign io_rdata = io_sel ? state_q : '0;

    AST_SIGN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        sreg[BIT_S] == (sreg[BIT_N] ^ sreg[BIT_V])); // R3
    AST_ACK_CLEARS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !sreg[BIT_I]); // R6
    AST_RETI_SETS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_stb && !irq_ack && !cli_stb && !io_wr_hit) |=> sreg[BIT_I]); // R7
    AST_GATE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        !sreg[BIT_I] |-> !irq_req); // R8
    AST_BST_LOADS_T: assert property (@(posedge clk) disable iff (!rst_n)
        (bst_en && !io_wr_hit) |=> sreg[BIT_T] == $past(bst_src[bit_sel])); // R9
    AST_IO_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr_hit && !irq_ack) |=> sreg[7:5] == $past(io_wdata[7:5]) && sreg[3:0] == $past(io_wdata[3:0])); // R11
endmodule

// File: tb/test_cpu_status_reg.sv
module test_cpu_status_reg;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alu_c = 0, alu_c_we = 0, alu_z = 0, alu_z_we = 0, alu_n = 0, alu_n_we = 0;
    logic alu_v = 0, alu_v_we = 0, alu_h = 0, alu_h_we = 0;
    logic sei_stb = 0, cli_stb = 0, reti_stb = 0, irq_ack = 0, bst_en = 0;
    logic [7:0] bst_src = 0, bld_in = 0, io_wdata = 0;
    logic [2:0] bit_sel = 0;
    logic [5:0] io_addr = 0;
    logic io_we = 0;
    logic [3:0] irq_src = 0, irq_en = 0;
    logic [7:0] bld_out, io_rdata, sreg;
    logic irq_req;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cpu_status_reg #(.NUM_IRQ(4)) i_cpu_status_reg (
        .clk(clk), .rst_n(rst_n),
        .alu_c(alu_c), .alu_c_we(alu_c_we), .alu_z(alu_z), .alu_z_we(alu_z_we),
        .alu_n(alu_n), .alu_n_we(alu_n_we), .alu_v(alu_v), .alu_v_we(alu_v_we),
        .alu_h(alu_h), .alu_h_we(alu_h_we),
        .sei_stb(sei_stb), .cli_stb(cli_stb), .reti_stb(reti_stb), .irq_ack(irq_ack),
        .bst_en(bst_en), .bst_src(bst_src), .bit_sel(bit_sel),
        .bld_in(bld_in), .bld_out(bld_out),
        .io_addr(io_addr), .io_we(io_we), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .irq_src(irq_src), .irq_en(irq_en), .irq_req(irq_req), .sreg(sreg)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        {alu_c_we, alu_z_we, alu_n_we, alu_v_we, alu_h_we} = '0;
        {sei_stb, cli_stb, reti_stb, irq_ack, bst_en, io_we} = '0;
    endtask

    task automatic io_wr(input logic [5:0] a, input logic [7:0] d);
        io_addr = a; io_wdata = d; io_we = 1; step();
    endtask

    task automatic t_reset();
        irq_src = 4'hF; irq_en = 4'hF;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        step();
        check("R1 sreg", sreg, 8'h00);
        check("R1 irq_req", {7'b0, irq_req}, 8'h00);
    endtask

    task automatic t_alu();
        io_wr(6'h3F, 8'h00);
        {alu_c, alu_z, alu_n, alu_v, alu_h} = '1;
        {alu_c_we, alu_z_we, alu_n_we, alu_v_we, alu_h_we} = '1;
        step();
        check("R2 all flags", sreg, 8'h2F);
        alu_n = 0; alu_n_we = 1; alu_c = 0;   // c has no enable
        step();
        check("R2/R3 only N", sreg, 8'h3B);
    endtask

    task automatic t_io();
        io_wr(6'h3F, 8'h10);
        check("R3 S ignored", sreg, 8'h00);
        io_wr(6'h3F, 8'h08);
        check("R3 S from V", sreg, 8'h18);
        io_wr(6'h3E, 8'hFF);
        check("R4 other addr write", sreg, 8'h18);
        io_addr = 6'h3F; #1;
        check("R4 read hit", io_rdata, 8'h18);
        io_addr = 6'h10; #1;
        check("R4 read miss", io_rdata, 8'h00);
    endtask

    task automatic t_sei_cli();
        io_wr(6'h3F, 8'h00);
        sei_stb = 1; step();
        check("R5 sei", sreg, 8'h80);
        cli_stb = 1; step();
        check("R5 cli", sreg, 8'h00);
        sei_stb = 1; step();
        sei_stb = 1; cli_stb = 1; step();
        check("R5 both", sreg, 8'h00);
    endtask

    task automatic t_ack_reti();
        io_wr(6'h3F, 8'hA5);            // I=1, H=1, S=0? V=0,N=1 -> S=1
        check("R3 after write", sreg, 8'hB5);
        irq_ack = 1; step();
        check("R6 ack", sreg, 8'h35);
        reti_stb = 1; step();
        check("R7 reti", sreg, 8'hB5);
        reti_stb = 1; irq_ack = 1; step();
        check("R6 ack beats reti", sreg, 8'h35);
        sei_stb = 1; irq_ack = 1; step();
        check("R6 ack beats sei", sreg, 8'h35);
        io_addr = 6'h3F; io_wdata = 8'h80; io_we = 1; irq_ack = 1; step();
        check("R6 ack beats io", sreg, 8'h00);
    endtask

    task automatic t_gate();
        io_wr(6'h3F, 8'h00);
        irq_src = 4'hF; irq_en = 4'hF; #1;
        check("R8 I low", {7'b0, irq_req}, 8'h00);
        sei_stb = 1; step();
        check("R8 I high", {7'b0, irq_req}, 8'h01);
        irq_en = 4'h0; #1;
        check("R8 none enabled", {7'b0, irq_req}, 8'h00);
        irq_src = 4'b0100; irq_en = 4'b0100; #1;
        check("R8 one match", {7'b0, irq_req}, 8'h01);
        irq_en = 4'b0010; #1;
        check("R8 mismatch", {7'b0, irq_req}, 8'h00);
    endtask

    task automatic t_bits();
        io_wr(6'h3F, 8'h00);
        bst_src = 8'b0010_0000; bit_sel = 3'd5; bst_en = 1; step();
        check("R9 store one", sreg, 8'h40);
        bld_in = 8'h00; bit_sel = 3'd3; #1;
        check("R10 load one", bld_out, 8'h08);
        bit_sel = 3'd4; bst_en = 1; step();
        check("R9 store zero", sreg, 8'h00);
        bld_in = 8'hFF; bit_sel = 3'd7; #1;
        check("R10 load zero", bld_out, 8'h7F);
    endtask

    task automatic t_prio();
        io_wr(6'h3F, 8'h00);
        {alu_c, alu_z, alu_n, alu_v, alu_h} = '1;
        {alu_c_we, alu_z_we, alu_n_we, alu_v_we, alu_h_we} = '1;
        sei_stb = 1; reti_stb = 1; bst_en = 1; bst_src = 8'hFF;
        io_addr = 6'h3F; io_wdata = 8'h00; io_we = 1;
        step();
        check("R11 io beats all", sreg, 8'h00);
        cli_stb = 1; io_addr = 6'h3F; io_wdata = 8'h81; io_we = 1;
        step();
        check("R11 io beats cli", sreg, 8'h81);
    endtask

    initial begin
        t_reset();
        t_alu();
        t_io();
        t_sei_cli();
        t_ack_reti();
        t_gate();
        t_bits();
        t_prio();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule